// File: doc/BRIEF.md
# Packet-Driven Memory-Mapped Transaction Engine

This block sits behind a byte-stream packet decoder. It takes each request packet as a stream of bytes and turns it into one or more 32-bit accesses on a simple memory-mapped master port. It then produces a response packet as a byte stream on its output side.

A request opens with an 8-byte header that carries an operation code, a byte count and a start address. Write requests carry their data words after the header. A write is answered by a short status header. A read is answered by the data words alone. Incrementing operations step the address one word at a time. Any request the block does not accept is answered with a reject header and makes no bus access.

The master port uses a read strobe and a write strobe, together with a stall input from the slave. The block keeps a strobe asserted until the stall input goes low, and the data beat completes in that cycle.

Top module: `pkt_xact_bridge`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `in_ready` is 1 and `out_valid`, `bus_read` and `bus_write` are 0.
- R2: The header is taken in this order: byte 0 is the code, byte 1 is ignored, bytes 2–3 are the byte count with the high byte first, and bytes 4–7 are the address with the most significant byte first. The first bus access uses exactly that address.
- R3: Code 0x00 with a count of 4 is a single write. The four data bytes that follow form one word, least significant byte first, and are written once at the header address.
- R4: Code 0x04 with a nonzero count that is a multiple of 4 writes count/4 words. The words go to the header address, then +4, +8 and so on, and each word is assembled least significant byte first.
- R5: A write is answered by exactly 4 bytes: the code XOR 0x80, then 0x00, then the count high byte, then the count low byte. `out_last` is 1 only on the fourth byte.
- R6: Code 0x10 with a count of 4 performs one read. Its response is the 4 data bytes, least significant first, with no header, and `out_last` is set on the fourth byte.
- R7: Code 0x14 with a nonzero count that is a multiple of 4 reads count/4 words at ascending word addresses. The response carries every word in order, least significant byte first, and `out_last` is set only on the final byte.
- R8: A strobe stays asserted, with a stable address (and stable write data for writes), until the cycle in which `bus_wait` is 0. Exactly one access completes per data word.
- R9: Several requests are rejected: any other code (including 0x7F, which means no operation), a single code whose count is not 4, and an incrementing code whose count is zero or not a multiple of 4. A rejected request makes no bus access. Its remaining input bytes are consumed up to and including the byte marked `in_last`. It is answered with 0xFF, 0x00, 0x00, 0x00.
- R10: `bus_read` and `bus_write` are never both 1. `in_ready` and `out_valid` are never both 1. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request byte present |
| in_ready | output | 1 | Engine accepts a request byte this cycle |
| in_data | input | 8 | Request byte |
| in_last | input | 1 | Final byte of the request packet |
| out_valid | output | 1 | Response byte present |
| out_ready | input | 1 | Downstream takes the response byte |
| out_data | output | 8 | Response byte |
| out_last | output | 1 | Final byte of the response packet |
| bus_addr | output | ADDR_W | Access address |
| bus_read | output | 1 | Read strobe |
| bus_write | output | 1 | Write strobe |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, taken when the read strobe completes |
| bus_wait | input | 1 | Slave stall; the access completes when it is 0 |

## Verification
Three things can coincide in a single clock: a word completing on the bus, the address stepping to the next word, and the word counter reaching its final value. This is most pressing when the slave answers with no stall on the very first strobe cycle. The bench provokes this with three slave modes: zero wait states, a fixed two-cycle stall, and a pseudo-random stall. In the random mode the output side is also throttled. For every transfer length from one to four words, the bench judges the result by the number of completed accesses, the logged address of each access, the slave memory contents and the returned bytes.

// File: rtl/pkt_xact_pkg.sv
package pkt_xact_pkg;

    // Operation codes carried in the first request byte
    localparam logic [7:0] OP_WR_ONE  = 8'h00;
    localparam logic [7:0] OP_WR_INC  = 8'h04;
    localparam logic [7:0] OP_RD_ONE  = 8'h10;
    localparam logic [7:0] OP_RD_INC  = 8'h14;
    localparam logic [7:0] OP_IDLE    = 8'h7F;

    // Response code handling
    localparam logic [7:0] RSP_FLIP   = 8'h80;
    localparam logic [7:0] RSP_REJECT = 8'hFF;

    typedef enum logic [2:0] {
        PH_HDR   = 3'd0,
        PH_WDAT  = 3'd1,
        PH_WBUS  = 3'd2,
        PH_RBUS  = 3'd3,
        PH_RDAT  = 3'd4,
        PH_DRAIN = 3'd5,
        PH_RESP  = 3'd6
    } xphase_e;

    typedef enum logic [1:0] {
        XK_REJECT = 2'd0,
        XK_WRITE  = 2'd1,
        XK_READ   = 2'd2
    } xkind_e;

endpackage

// File: rtl/pkt_xact_decode.sv
module pkt_xact_decode
    import pkt_xact_pkg::*;
#(
    parameter int SIZE_W     = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic [7:0]        code_i,
    input  logic [SIZE_W-1:0] size_i,
    output xkind_e            kind_o,
    output logic              incr_o
);
    localparam int LSB_W = $clog2(WORD_BYTES);

    logic aligned;
    logic nonzero;
    logic one_word;

    always_comb begin
        aligned  = (size_i[LSB_W-1:0] == '0);
        nonzero  = (size_i != '0);
        one_word = (size_i == SIZE_W'(WORD_BYTES));
        kind_o   = XK_REJECT;
        incr_o   = 1'b0;
        case (code_i)
            OP_WR_ONE: begin
                kind_o = one_word ? XK_WRITE : XK_REJECT;
            end
            OP_WR_INC: begin
                kind_o = (aligned && nonzero) ? XK_WRITE : XK_REJECT;
                incr_o = 1'b1;
            end
            OP_RD_ONE: begin
                kind_o = one_word ? XK_READ : XK_REJECT;
            end
            OP_RD_INC: begin
                kind_o = (aligned && nonzero) ? XK_READ : XK_REJECT;
                incr_o = 1'b1;
            end
            OP_IDLE: begin
                kind_o = XK_REJECT;
            end
            default: begin
                kind_o = XK_REJECT;
            end
        endcase
    end

endmodule

// File: rtl/pkt_xact_lane.sv
module pkt_xact_lane #(
    parameter  int WORD_BYTES = 4,
    localparam int SEL_W      = $clog2(WORD_BYTES)
) (
    input  logic [WORD_BYTES*8-1:0] word_i,
    input  logic [SEL_W-1:0]        sel_i,
    output logic [7:0]              byte_o
);
    logic [7:0] lanes [WORD_BYTES];

    // Lane 0 is the least significant byte and leaves first
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign lanes[g] = word_i[g*8 +: 8];
    end

    assign byte_o = lanes[sel_i];

endmodule

// File: rtl/pkt_xact_resp.sv
module pkt_xact_resp
    import pkt_xact_pkg::*;
#(
    parameter  int SIZE_W    = 16,
    localparam int SIZE_B    = SIZE_W / 8,
    localparam int RSP_BYTES = 2 + SIZE_B,
    localparam int SEL_W     = $clog2(RSP_BYTES)
) (
    input  logic [7:0]        code_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              reject_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [7:0]        byte_o
);
    logic [7:0] field [RSP_BYTES];

    assign field[0] = reject_i ? RSP_REJECT : (code_i ^ RSP_FLIP);
    assign field[1] = 8'h00;

    // Byte count, most significant byte first
    for (genvar g = 0; g < SIZE_B; g++) begin : g_size
        assign field[2+g] = reject_i ? 8'h00 : size_i[(SIZE_B-1-g)*8 +: 8];
    end

    assign byte_o = field[sel_i];

endmodule

// File: rtl/pkt_xact_bridge.sv
module pkt_xact_bridge
    import pkt_xact_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_read,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_wait
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int ADDR_B     = ADDR_W / 8;
    localparam int SIZE_B     = SIZE_W / 8;
    localparam int HDR_BYTES  = 2 + SIZE_B + ADDR_B;
    localparam int RSP_BYTES  = 2 + SIZE_B;
    localparam int IDX_W      = $clog2(HDR_BYTES);
    localparam int WSEL_W     = $clog2(WORD_BYTES);
    localparam int RSEL_W     = $clog2(RSP_BYTES);
    localparam int SHIFT      = $clog2(WORD_BYTES);

    localparam logic [IDX_W-1:0] IDX_SIZE0 = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_ADDR0 = IDX_W'(2 + SIZE_B);
    localparam logic [IDX_W-1:0] IDX_HLAST = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_WLAST = IDX_W'(WORD_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_RLAST = IDX_W'(RSP_BYTES - 1);

    typedef struct packed {
        xphase_e           ph;
        xkind_e            kind;
        logic              incr;
        logic [7:0]        code;
        logic [SIZE_W-1:0] size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] word;
        logic [IDX_W-1:0]  idx;
        logic [SIZE_W-1:0] left;
    } xreg_t;

    localparam xreg_t XREG_RESET = '0;

    xreg_t r_d, r_q;

    xkind_e            dec_kind;
    logic              dec_incr;
    logic [7:0]        lane_byte;
    logic [7:0]        rsp_byte;
    logic              in_fire;
    logic              last_word;
    logic [ADDR_W-1:0] step;

    pkt_xact_decode #(
        .SIZE_W     (SIZE_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_decode (
        .code_i (r_q.code),
        .size_i (r_q.size),
        .kind_o (dec_kind),
        .incr_o (dec_incr)
    );

    pkt_xact_lane #(
        .WORD_BYTES (WORD_BYTES)
    ) u_lane (
        .word_i (r_q.word),
        .sel_i  (r_q.idx[WSEL_W-1:0]),
        .byte_o (lane_byte)
    );

    pkt_xact_resp #(
        .SIZE_W (SIZE_W)
    ) u_resp (
        .code_i   (r_q.code),
        .size_i   (r_q.size),
        .reject_i (r_q.kind == XK_REJECT),
        .sel_i    (r_q.idx[RSEL_W-1:0]),
        .byte_o   (rsp_byte)
    );

    // Port-side views of the registered state
    always_comb begin
        in_ready  = (r_q.ph == PH_HDR) || (r_q.ph == PH_WDAT) || (r_q.ph == PH_DRAIN);
        out_valid = (r_q.ph == PH_RDAT) || (r_q.ph == PH_RESP);
        bus_read  = (r_q.ph == PH_RBUS);
        bus_write = (r_q.ph == PH_WBUS);
        bus_addr  = r_q.addr;
        bus_wdata = r_q.word;
        last_word = (r_q.left == SIZE_W'(1));
        if (r_q.ph == PH_RDAT) begin
            out_data = lane_byte;
            out_last = (r_q.idx == IDX_WLAST) && last_word;
        end else begin
            out_data = rsp_byte;
            out_last = (r_q.idx == IDX_RLAST);
        end
    end

    assign in_fire = in_valid && in_ready;
    assign step    = r_q.incr ? ADDR_W'(WORD_BYTES) : '0;

    // Next-state computation
    always_comb begin
        r_d = r_q;
        case (r_q.ph)
            PH_HDR: begin
                if (in_fire) begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                    if (r_q.idx == '0) begin
                        r_d.code = in_data;
                    end else if ((r_q.idx >= IDX_SIZE0) && (r_q.idx < IDX_ADDR0)) begin
                        r_d.size = {r_q.size[SIZE_W-9:0], in_data};
                    end else if (r_q.idx >= IDX_ADDR0) begin
                        r_d.addr = {r_q.addr[ADDR_W-9:0], in_data};
                    end
                    if (r_q.idx == IDX_HLAST) begin
                        r_d.idx  = '0;
                        r_d.kind = dec_kind;
                        r_d.incr = dec_incr;
                        r_d.left = r_q.size >> SHIFT;
                        case (dec_kind)
                            XK_WRITE: r_d.ph = PH_WDAT;
                            XK_READ:  r_d.ph = PH_RBUS;
                            default:  r_d.ph = in_last ? PH_RESP : PH_DRAIN;
                        endcase
                    end
                end
            end
            PH_DRAIN: begin
                if (in_fire && in_last) begin
                    r_d.ph  = PH_RESP;
                    r_d.idx = '0;
                end
            end
            PH_WDAT: begin
                if (in_fire) begin
                    r_d.word = {in_data, r_q.word[DATA_W-1:8]};
                    r_d.idx  = r_q.idx + IDX_W'(1);
                    if (r_q.idx == IDX_WLAST) begin
                        r_d.idx = '0;
                        r_d.ph  = PH_WBUS;
                    end
                end
            end
            PH_WBUS: begin
                if (!bus_wait) begin
                    r_d.left = r_q.left - SIZE_W'(1);
                    r_d.addr = r_q.addr + step;
                    r_d.ph   = last_word ? PH_RESP : PH_WDAT;
                end
            end
            PH_RBUS: begin
                if (!bus_wait) begin
                    r_d.word = bus_rdata;
                    r_d.idx  = '0;
                    r_d.ph   = PH_RDAT;
                end
            end
            PH_RDAT: begin
                if (out_ready) begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                    if (r_q.idx == IDX_WLAST) begin
                        r_d.idx  = '0;
                        r_d.left = r_q.left - SIZE_W'(1);
                        r_d.addr = r_q.addr + step;
                        r_d.ph   = last_word ? PH_HDR : PH_RBUS;
                    end
                end
            end
            PH_RESP: begin
                if (out_ready) begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                    if (r_q.idx == IDX_RLAST) begin
                        r_d.idx = '0;
                        r_d.ph  = PH_HDR;
                    end
                end
            end
            default: begin
                r_d = XREG_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= XREG_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    // R8: a stalled write keeps its strobe, address and data
    p_hold_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && bus_wait) |=> (bus_write && $stable(bus_addr) && $stable(bus_wdata)));

    // R8: a stalled read keeps its strobe and address
    p_hold_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && bus_wait) |=> (bus_read && $stable(bus_addr)));

    // R4: after an accepted incrementing write that is not the last, the address moves one word
    p_incr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && !bus_wait && r_q.incr && !last_word)
        |=> (bus_addr == $past(bus_addr) + ADDR_W'(WORD_BYTES)));

    // R9: a rejected request never drives a strobe
    p_reject_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.kind == XK_REJECT) |-> !(bus_read || bus_write));

    // R10: exclusive strobes, and input and output sides never active together
    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_read && bus_write) && !(in_ready && out_valid));

    // R10: a stalled response byte is held
    p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

// File: tb/pkt_xact_bridge_bench.sv
module pkt_xact_bridge_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_data;
    logic        in_last;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_data;
    logic        out_last;
    logic [31:0] bus_addr;
    logic        bus_read;
    logic        bus_write;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_wait;

    int nchk  = 0;
    int nfail = 0;
    int wait_mode = 0;
    int stall_mode = 0;
    int stall_cnt = 0;

    logic [31:0] mem     [64];
    logic [31:0] exp_mem [64];
    logic [31:0] addr_log[16];
    int          acc_n;
    int          wcnt;
    logic [15:0] lfsr;

    pkt_xact_bridge u_pkt_xact_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last),
        .bus_addr  (bus_addr),
        .bus_read  (bus_read),
        .bus_write (bus_write),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_wait  (bus_wait)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] seed_word(input int i);
        return (32'(i + 1) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] wr_word(input int salt, input int i);
        return (32'(salt) * 32'h0101_0101) ^ (32'(i) * 32'h1111_0000) ^ 32'h1357_9BDF;
    endfunction

    // Slave model: memory indexed by address bits 7:2
    assign bus_rdata = mem[bus_addr[7:2]];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= seed_word(i);
            acc_n <= 0;
            wcnt  <= 0;
        end else if ((bus_read || bus_write) && !bus_wait) begin
            addr_log[acc_n % 16] <= bus_addr;
            acc_n <= acc_n + 1;
            wcnt  <= 0;
            if (bus_write) mem[bus_addr[7:2]] <= bus_wdata;
        end else if (bus_read || bus_write) begin
            wcnt <= wcnt + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            lfsr     <= 16'hACE1;
            bus_wait <= 1'b0;
        end else begin
            lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (wait_mode == 0)      bus_wait <= 1'b0;
            else if (wait_mode == 1) bus_wait <= (wcnt < 2);
            else                     bus_wait <= lfsr[0];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic l);
        logic got;
        in_valid = 1'b1;
        in_data  = b;
        in_last  = l;
        do begin
            got = in_ready;
            @(negedge clk);
        end while (!got);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic l);
        logic got;
        do begin
            out_ready = (stall_mode != 0 && (stall_cnt % 3) == 1) ? 1'b0 : 1'b1;
            stall_cnt++;
            got = out_valid && out_ready;
            b   = out_data;
            l   = out_last;
            @(negedge clk);
        end while (!got);
        out_ready = 1'b0;
    endtask

    task automatic send_hdr(input logic [7:0] code, input logic [15:0] size,
                            input logic [31:0] addr, input logic end_pkt);
        send_byte(code, 1'b0);
        send_byte(8'hA5, 1'b0);
        send_byte(size[15:8], 1'b0);
        send_byte(size[7:0], 1'b0);
        send_byte(addr[31:24], 1'b0);
        send_byte(addr[23:16], 1'b0);
        send_byte(addr[15:8], 1'b0);
        send_byte(addr[7:0], end_pkt);
    endtask

    task automatic do_write(input logic [7:0] code, input logic [31:0] base, input int n, input int salt);
        logic [15:0] size;
        logic [7:0]  b;
        logic        l;
        logic [7:0]  expb [4];
        logic [31:0] w;
        int          start;
        string       tg;
        tg    = (code == 8'h00) ? "R3" : "R4";
        size  = 16'(n * 4);
        start = acc_n;
        send_hdr(code, size, base, 1'b0);
        for (int i = 0; i < n; i++) begin
            w = wr_word(salt, i);
            exp_mem[(base[7:2] + 6'(i))] = w;
            for (int k = 0; k < 4; k++) send_byte(w[k*8 +: 8], (i == n-1) && (k == 3));
        end
        expb[0] = code ^ 8'h80;
        expb[1] = 8'h00;
        expb[2] = size[15:8];
        expb[3] = size[7:0];
        for (int k = 0; k < 4; k++) begin
            recv_byte(b, l);
            chk(b == expb[k], "R5 write response byte", 32'(b), 32'(expb[k]));
            chk(l == (k == 3), "R5 write response last flag", 32'(l), 32'(k == 3));
        end
        chk(acc_n - start == n, "R8 access count per write word", 32'(acc_n - start), 32'(n));
        for (int i = 0; i < n; i++) begin
            chk(addr_log[(start + i) % 16] == base + 32'(4 * i),
                (i == 0) ? "R2 header address on first write" : tg,
                addr_log[(start + i) % 16], base + 32'(4 * i));
            chk(mem[base[7:2] + 6'(i)] == exp_mem[base[7:2] + 6'(i)], tg,
                mem[base[7:2] + 6'(i)], exp_mem[base[7:2] + 6'(i)]);
        end
    endtask

    task automatic do_read(input logic [7:0] code, input logic [31:0] base, input int n);
        logic [7:0]  b;
        logic        l;
        logic [31:0] w;
        int          start;
        string       tg;
        tg    = (code == 8'h10) ? "R6" : "R7";
        start = acc_n;
        send_hdr(code, 16'(n * 4), base, 1'b1);
        for (int i = 0; i < n; i++) begin
            w = exp_mem[base[7:2] + 6'(i)];
            for (int k = 0; k < 4; k++) begin
                recv_byte(b, l);
                chk(b == w[k*8 +: 8], tg, 32'(b), 32'(w[k*8 +: 8]));
                chk(l == ((i == n-1) && (k == 3)), tg, 32'(l), 32'((i == n-1) && (k == 3)));
            end
        end
        chk(acc_n - start == n, "R8 access count per read word", 32'(acc_n - start), 32'(n));
        for (int i = 0; i < n; i++)
            chk(addr_log[(start + i) % 16] == base + 32'(4 * i), tg,
                addr_log[(start + i) % 16], base + 32'(4 * i));
    endtask

    task automatic do_bad(input logic [7:0] code, input logic [15:0] size,
                          input logic [31:0] base, input int extra);
        logic [7:0] b;
        logic       l;
        logic [7:0] expb [4];
        int         start;
        start = acc_n;
        send_hdr(code, size, base, extra == 0);
        for (int e = 0; e < extra; e++) send_byte(8'hC3 ^ 8'(e), e == extra - 1);
        expb[0] = 8'hFF; expb[1] = 8'h00; expb[2] = 8'h00; expb[3] = 8'h00;
        for (int k = 0; k < 4; k++) begin
            recv_byte(b, l);
            chk(b == expb[k], "R9 reject response byte", 32'(b), 32'(expb[k]));
            chk(l == (k == 3), "R9 reject last flag", 32'(l), 32'(k == 3));
        end
        chk(acc_n == start, "R9 no bus access on reject", 32'(acc_n - start), 32'd0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R10 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [31:0] base;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_data   = 8'h00;
        in_last   = 1'b0;
        out_ready = 1'b0;
        for (int i = 0; i < 64; i++) exp_mem[i] = seed_word(i);
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready in reset", 32'(in_ready), 32'd1);
        chk(out_valid == 1'b0, "R1 out_valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk(!bus_read && !bus_write, "R1 strobes idle after reset", 32'({bus_read, bus_write}), 32'd0);

        for (int mode = 0; mode < 3; mode++) begin
            wait_mode  = mode;
            stall_mode = (mode == 2) ? 1 : 0;
            base = 32'hC0DE_0000 | 32'(((mode * 11) & 31) << 2) | 32'(mode << 20);
            do_write(8'h00, base, 1, mode + 7);
            do_read(8'h10, base, 1);
            for (int n = 1; n <= 4; n++) begin
                base = 32'h4A00_0000 | 32'(((mode * 7 + n * 5) & 31) << 2) | 32'(n << 16);
                do_write(8'h04, base, n, mode * 4 + n);
                do_read(8'h14, base, n);
                do_read(8'h10, base + 32'(4 * (n - 1)), 1);
            end
        end

        wait_mode  = 1;
        stall_mode = 0;
        do_bad(8'h7F, 16'd4, 32'h0000_0010, 0);
        do_bad(8'h01, 16'd4, 32'h0000_0020, 4);
        do_bad(8'h10, 16'd8, 32'h0000_0030, 0);
        do_bad(8'h00, 16'd8, 32'h0000_0040, 8);
        do_bad(8'h04, 16'd6, 32'h0000_0050, 6);
        do_bad(8'h14, 16'd0, 32'h0000_0060, 0);
        // R9: engine still serves a normal read after the rejects
        do_read(8'h14, 32'h4A00_0040, 2);

        finish_run();
    end

endmodule